// File: doc/BRIEF.md
# Internal Reset Sequencer with Open-Drain Reset Pin

This block collects the reset requests raised inside a chip and turns each one into a timed recovery sequence. The requests are power-on, low-voltage, illegal address, illegal opcode and watchdog timeout. A low level driven onto the bidirectional reset pin from outside also counts as a request. The sequence holds the chip-wide internal reset and, if enabled, pulls the external reset pin low so that other devices on the board reset as well. After that it gives the CPU a short window for fetching the reset vector. All timing is counted on a fast reference clock that runs at four times the bus clock.

Power-class requests (power-on, low-voltage) start with a long stabilisation wait. Every request then goes through a pin-drive phase and an internal-hold phase, followed by the vector-fetch window. Power-on also resets the sequencer itself. The low-voltage request, the watchdog request and the external pin level are asynchronous and pass through two-flop synchronizers. A cause register records which requests started a sequence, so firmware can read why the chip was reset.

Top module: `rstseq_top`

## Requirements
- R1: While `por_in` is high, `irst`=1, `rst_pin_oe`=0 and `vec_fetch`=0, and `cause_status` reads 6'b000001. Status bit positions: 0 power-on, 1 low-voltage, 2 illegal address, 3 illegal opcode, 4 watchdog, 5 external pin.
- R2: After `por_in` falls, `irst` stays high for 4160 clock cycles. This count includes the cycle in which `por_in` falls. `vec_fetch` is then high for 3 cycles, for 4163 cycles in total.
- R3: An `illaddr_req` or `illop_req` seen high on a rising edge raises `irst` from that edge. `irst` is held for 64 cycles, followed by 3 cycles of `vec_fetch`. `irst` is never high together with `vec_fetch`.
- R4: `rst_pin_oe` is high for exactly 32 cycles. These are the first 32 cycles of the 64-cycle pin-drive plus hold window, which comes after any stabilisation wait. `rst_pin_oe` is high only while `irst` is high.
- R5: With `pin_en`=0, `rst_pin_oe` stays 0 and the `irst` timing is unchanged.
- R6: `wdog_req` and `lvi_req` pass through a two-flop synchronizer. `irst` rises after the third rising edge that follows the request.
- R7: A low-voltage request runs a 4096-cycle stabilisation wait before the 64-cycle window and the 3-cycle vector window.
- R8: A short-class request during pin-drive, hold or vector fetch restarts the sequence at pin-drive. A low-voltage request during any phase restarts it at stabilisation. A short-class request during stabilisation is ignored and does not set its status bit.
- R9: When a sequence starts, the status bits of the accepted causes are set and stay set. Power-on clears every bit except bit 0.
- R10: When idle with `pin_en`=1, a low level on `rst_pin_in` starts a short sequence after the two-flop synchronizer and sets status bit 5. With `pin_en`=0 the pin input is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock (4x bus clock) |
| por_in | input | 1 | Power-on request, asynchronous, active high; resets the sequencer |
| lvi_req | input | 1 | Low-voltage request, asynchronous |
| illaddr_req | input | 1 | Illegal-address request, synchronous to `clk` |
| illop_req | input | 1 | Illegal-opcode request, synchronous to `clk` |
| wdog_req | input | 1 | Watchdog timeout request, asynchronous |
| pin_en | input | 1 | Configuration bit: reset function of the pin enabled |
| rst_pin_in | input | 1 | Level read back from the reset pin |
| rst_pin_oe | output | 1 | Open-drain enable: pulls the pin low when 1 |
| irst | output | 1 | Internal chip-wide reset |
| vec_fetch | output | 1 | Vector-fetch window after reset release |
| cause_status | output | 6 | Latched reset causes |

## Verification
The bench triggers each cause on its own. Measuring the start latency separates synchronous requests from synchronized ones, and measuring the stabilisation length separates power-class requests from short-class ones. Each short cause is run with the pin enabled and with it disabled, which shows whether the drive window follows the enable bit while the internal timing stays fixed. Three restart cases are tried: a short request landing in the hold phase, a low-voltage request landing in the hold phase, and a short request landing in stabilisation. These show the restart points and the priority between classes through the total length of `irst`. After each run the status register is compared with a bench model of which causes were accepted, including the clear on a second power-on.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_STAB  = 3'd1,
    PH_DRIVE = 3'd2,
    PH_HOLD  = 3'd3,
    PH_VEC   = 3'd4
  } phase_e;

  localparam int NCAUSE  = 6;
  localparam int C_POR   = 0;
  localparam int C_LVI   = 1;
  localparam int C_IADDR = 2;
  localparam int C_IOP   = 3;
  localparam int C_WDOG  = 4;
  localparam int C_PIN   = 5;

  // number of clock cycles a phase occupies
  function automatic int phase_len(phase_e p, int stab, int drive, int hold, int vec);
    case (p)
      PH_STAB:  return stab;
      PH_DRIVE: return drive;
      PH_HOLD:  return hold;
      PH_VEC:   return vec;
      default:  return 1;
    endcase
  endfunction

  // successor of a phase once its count runs out
  function automatic phase_e phase_after(phase_e p);
    case (p)
      PH_STAB:  return PH_DRIVE;
      PH_DRIVE: return PH_HOLD;
      PH_HOLD:  return PH_VEC;
      default:  return PH_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) chain <= '0;
    else      chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rstseq_timer.sv
module rstseq_timer
  import rstseq_pkg::*;
#(
  parameter int STAB_CYC  = 4096,
  parameter int DRIVE_CYC = 32,
  parameter int HOLD_CYC  = 32,
  parameter int VEC_CYC   = 3
) (
  input  logic   clk,
  input  logic   arst,
  input  logic   pwr_start,
  input  logic   short_start,
  output phase_e phase
);
  localparam int L1      = (STAB_CYC > DRIVE_CYC) ? STAB_CYC : DRIVE_CYC;
  localparam int L2      = (HOLD_CYC > VEC_CYC) ? HOLD_CYC : VEC_CYC;
  localparam int LONGEST = (L1 > L2) ? L1 : L2;
  localparam int CW      = $clog2(LONGEST + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic          at_end;

  always_comb last = CW'(phase_len(phase, STAB_CYC, DRIVE_CYC, HOLD_CYC, VEC_CYC) - 1);
  assign at_end = (cnt == last);

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      phase <= PH_STAB;
      cnt   <= '0;
    end else if (pwr_start) begin
      phase <= PH_STAB;
      cnt   <= '0;
    end else if (short_start) begin
      phase <= PH_DRIVE;
      cnt   <= '0;
    end else if (phase != PH_IDLE) begin
      if (at_end) begin
        phase <= phase_after(phase);
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rstseq_arb.sv
module rstseq_arb
  import rstseq_pkg::*;
(
  input  phase_e              phase,
  input  logic                pin_en,
  input  logic                lvi_s,
  input  logic                iaddr,
  input  logic                iop,
  input  logic                wdog_s,
  input  logic                pin_low_s,
  output logic                pwr_start,
  output logic                short_start,
  output logic [NCAUSE-1:0]   accepted
);
  logic pin_term;
  logic short_any;

  always_comb begin
    pin_term    = pin_low_s & pin_en & (phase == PH_IDLE);
    short_any   = iaddr | iop | wdog_s | pin_term;
    pwr_start   = lvi_s;
    short_start = short_any & ~lvi_s & (phase != PH_STAB);
    accepted    = '0;
    if (pwr_start) begin
      accepted[C_LVI] = 1'b1;
    end else if (short_start) begin
      accepted[C_IADDR] = iaddr;
      accepted[C_IOP]   = iop;
      accepted[C_WDOG]  = wdog_s;
      accepted[C_PIN]   = pin_term;
    end
  end
endmodule

// File: rtl/rstseq_status.sv
module rstseq_status
  import rstseq_pkg::*;
(
  input  logic              clk,
  input  logic              arst,
  input  logic              start,
  input  logic [NCAUSE-1:0] accepted,
  output logic [NCAUSE-1:0] status
);
  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      status        <= '0;
      status[C_POR] <= 1'b1;
    end else if (start) begin
      status <= status | accepted;
    end
  end
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int STAB_CYC    = 4096,
  parameter int DRIVE_CYC   = 32,
  parameter int HOLD_CYC    = 32,
  parameter int VEC_CYC     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por_in,
  input  logic              lvi_req,
  input  logic              illaddr_req,
  input  logic              illop_req,
  input  logic              wdog_req,
  input  logic              pin_en,
  input  logic              rst_pin_in,
  output logic              rst_pin_oe,
  output logic              irst,
  output logic              vec_fetch,
  output logic [NCAUSE-1:0] cause_status
);
  localparam int NASYNC = 3;

  logic [NASYNC-1:0] async_raw;
  logic [NASYNC-1:0] async_sync;
  logic              pwr_start;
  logic              short_start;
  logic              seq_start;
  logic [NCAUSE-1:0] accepted;
  phase_e            phase;

  // index 0: low-voltage, 1: watchdog, 2: pin pulled low
  assign async_raw = {~rst_pin_in, wdog_req, lvi_req};

  for (genvar gi = 0; gi < NASYNC; gi++) begin : g_sync
    rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .arst (por_in),
      .d    (async_raw[gi]),
      .q    (async_sync[gi])
    );
  end

  rstseq_arb u_arb (
    .phase       (phase),
    .pin_en      (pin_en),
    .lvi_s       (async_sync[0]),
    .iaddr       (illaddr_req),
    .iop         (illop_req),
    .wdog_s      (async_sync[1]),
    .pin_low_s   (async_sync[2]),
    .pwr_start   (pwr_start),
    .short_start (short_start),
    .accepted    (accepted)
  );

  assign seq_start = pwr_start | short_start;

  rstseq_timer #(
    .STAB_CYC  (STAB_CYC),
    .DRIVE_CYC (DRIVE_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .VEC_CYC   (VEC_CYC)
  ) u_timer (
    .clk         (clk),
    .arst        (por_in),
    .pwr_start   (pwr_start),
    .short_start (short_start),
    .phase       (phase)
  );

  rstseq_status u_status (
    .clk      (clk),
    .arst     (por_in),
    .start    (seq_start),
    .accepted (accepted),
    .status   (cause_status)
  );

  assign irst       = (phase == PH_STAB) | (phase == PH_DRIVE) | (phase == PH_HOLD);
  assign vec_fetch  = (phase == PH_VEC);
  assign rst_pin_oe = (phase == PH_DRIVE) & pin_en;
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk #(
  parameter int DRIVE_CYC = 32,
  parameter int W         = 6
) (
  input logic         clk,
  input logic         por_in,
  input logic         pin_en,
  input logic         rst_pin_oe,
  input logic         irst,
  input logic         vec_fetch,
  input logic [W-1:0] cause_status,
  input logic         seq_start
);
  int oe_run;

  always_ff @(posedge clk or posedge por_in) begin
    if (por_in)          oe_run <= 0;
    else if (seq_start)  oe_run <= 0;
    else if (rst_pin_oe) oe_run <= oe_run + 1;
    else                 oe_run <= 0;
  end

  p_oe_needs_enable_r5: assert property (@(posedge clk) disable iff (por_in)
    rst_pin_oe |-> pin_en);

  p_oe_inside_irst_r4: assert property (@(posedge clk) disable iff (por_in)
    rst_pin_oe |-> irst);

  p_oe_width_r4: assert property (@(posedge clk) disable iff (por_in)
    rst_pin_oe |-> (oe_run < DRIVE_CYC));

  p_vec_follows_irst_r3: assert property (@(posedge clk) disable iff (por_in)
    $fell(irst) |-> vec_fetch);

  p_vec_excludes_irst_r3: assert property (@(posedge clk) disable iff (por_in)
    vec_fetch |-> !irst);

  p_start_raises_irst_r8: assert property (@(posedge clk) disable iff (por_in)
    seq_start |=> irst);

  p_status_stable_r9: assert property (@(posedge clk) disable iff (por_in)
    !seq_start |=> $stable(cause_status));
endmodule

bind rstseq_top rstseq_chk #(.DRIVE_CYC(DRIVE_CYC), .W(6)) u_chk (
  .clk          (clk),
  .por_in       (por_in),
  .pin_en       (pin_en),
  .rst_pin_oe   (rst_pin_oe),
  .irst         (irst),
  .vec_fetch    (vec_fetch),
  .cause_status (cause_status),
  .seq_start    (seq_start)
);

// File: tb/test_rstseq_top.sv
module test_rstseq_top;
  localparam int STAB  = 4096;
  localparam int WIN   = 64;
  localparam int DRV   = 32;
  localparam int VEC   = 3;
  localparam int SYNCL = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic por_in, lvi_req, illaddr_req, illop_req, wdog_req, pin_en, ext_low;
  logic rst_pin_in, rst_pin_oe, irst, vec_fetch;
  logic [5:0] cause_status;

  // open-drain pin with pull-up
  assign rst_pin_in = ~(rst_pin_oe | ext_low);

  rstseq_top i_rstseq_top (
    .clk          (clk),
    .por_in       (por_in),
    .lvi_req      (lvi_req),
    .illaddr_req  (illaddr_req),
    .illop_req    (illop_req),
    .wdog_req     (wdog_req),
    .pin_en       (pin_en),
    .rst_pin_in   (rst_pin_in),
    .rst_pin_oe   (rst_pin_oe),
    .irst         (irst),
    .vec_fetch    (vec_fetch),
    .cause_status (cause_status)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [5:0] exp_st;
  int r_lat, r_irst, r_oe, r_first_oe, r_vec;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_cause(int c, logic v);
    case (c)
      1: lvi_req     = v;
      2: illaddr_req = v;
      3: illop_req   = v;
      4: wdog_req    = v;
      5: ext_low     = v;
      default: ;
    endcase
  endtask

  // cause 0: no new request (power-on release just done)
  task automatic run_seq(int cause, int inj_at, int inj_cause);
    bit seen_vec = 0;
    r_lat = -1; r_irst = 0; r_oe = 0; r_first_oe = -1; r_vec = 0;
    if (cause != 0) begin
      repeat (4) @(negedge clk);
      set_cause(cause, 1'b1);
    end
    for (int k = 1; k <= 12000; k++) begin
      @(negedge clk);
      if (k == 1) set_cause(cause, 1'b0);
      if (inj_at > 0 && k == inj_at) set_cause(inj_cause, 1'b1);
      if (inj_at > 0 && k == inj_at + 1) set_cause(inj_cause, 1'b0);
      if (irst && r_lat < 0) r_lat = k;
      if (irst) r_irst++;
      if (rst_pin_oe) begin
        r_oe++;
        if (r_first_oe < 0) r_first_oe = k;
      end
      if (vec_fetch) begin
        r_vec++;
        seen_vec = 1;
      end
      if (seen_vec && !vec_fetch && !irst) break;
    end
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int quiet;
    por_in = 1'b1; lvi_req = 0; illaddr_req = 0; illop_req = 0; wdog_req = 0;
    pin_en = 1'b1; ext_low = 1'b0;
    exp_st = 6'b000001;
    repeat (4) @(negedge clk);
    chk("R1 irst under power-on", irst, 1);
    chk("R1 pin drive under power-on", rst_pin_oe, 0);
    chk("R1 vec_fetch under power-on", vec_fetch, 0);
    chk("R1 status under power-on", cause_status, 1);

    // release; cycle of release counts as first stabilisation cycle
    por_in = 1'b0;
    run_seq(0, 0, 0);
    chk("R2 irst already high", r_lat, 1);
    chk("R2 irst length after release", r_irst, STAB + WIN - 1);
    chk("R2 vector window", r_vec, VEC);
    chk("R4 pin drive length power-on", r_oe, DRV);
    chk("R4 pin drive start power-on", r_first_oe, STAB);
    chk("R9 status after power-on", cause_status, exp_st);

    for (int c = 2; c <= 5; c++) begin
      int exp_lat;
      string rq;
      exp_lat = (c <= 3) ? 1 : SYNCL;
      rq = (c == 5) ? "R10" : (c == 4) ? "R6" : "R3";
      run_seq(c, 0, 0);
      chk($sformatf("%s latency cause %0d", rq, c), r_lat, exp_lat);
      chk($sformatf("R3 irst length cause %0d", c), r_irst, WIN);
      chk($sformatf("R3 vector window cause %0d", c), r_vec, VEC);
      chk($sformatf("R4 pin drive length cause %0d", c), r_oe, DRV);
      chk($sformatf("R4 pin drive start cause %0d", c), r_first_oe, exp_lat);
      exp_st[c] = 1'b1;
      chk($sformatf("R9 status cause %0d", c), cause_status, exp_st);
    end

    pin_en = 1'b0;
    for (int c = 2; c <= 4; c++) begin
      run_seq(c, 0, 0);
      chk($sformatf("R5 no pin drive cause %0d", c), r_oe, 0);
      chk($sformatf("R5 irst length unchanged cause %0d", c), r_irst, WIN);
      chk($sformatf("R5 vector window cause %0d", c), r_vec, VEC);
    end

    // pin pulled low externally while the function is disabled
    quiet = 0;
    @(negedge clk);
    ext_low = 1'b1;
    repeat (6) begin
      @(negedge clk);
      quiet += irst;
    end
    ext_low = 1'b0;
    repeat (6) begin
      @(negedge clk);
      quiet += irst;
    end
    chk("R10 pin ignored when disabled", quiet, 0);
    chk("R10 status unchanged when disabled", cause_status, exp_st);
    pin_en = 1'b1;

    // short request in hold phase restarts at pin drive
    run_seq(2, 40, 3);
    chk("R8 short restart irst length", r_irst, 40 + WIN);
    chk("R8 short restart pin drive", r_oe, 2 * DRV);
    chk("R8 short restart vector", r_vec, VEC);

    run_seq(1, 0, 0);
    chk("R6 low-voltage latency", r_lat, SYNCL);
    chk("R7 low-voltage irst length", r_irst, STAB + WIN);
    chk("R7 low-voltage pin drive start", r_first_oe, SYNCL + STAB);
    chk("R7 low-voltage pin drive length", r_oe, DRV);
    chk("R7 low-voltage vector", r_vec, VEC);
    exp_st[1] = 1'b1;
    chk("R9 status low-voltage", cause_status, exp_st);

    // low-voltage request in hold phase restarts at stabilisation
    run_seq(2, 40, 1);
    chk("R8 power restart irst length", r_irst, 40 + (SYNCL - 1) + STAB + WIN);
    chk("R8 power restart pin drive", r_oe, 2 * DRV);
    chk("R8 power restart vector", r_vec, VEC);

    // second power-on clears status
    @(negedge clk);
    por_in = 1'b1;
    repeat (3) @(negedge clk);
    exp_st = 6'b000001;
    chk("R9 power-on clears status", cause_status, exp_st);
    por_in = 1'b0;
    run_seq(0, 100, 2);
    chk("R8 short request ignored in stabilisation", r_irst, STAB + WIN - 1);
    chk("R8 ignored request leaves status", cause_status, exp_st);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule